// File: doc/BRIEF.md
# Shared Dual-Pipe Integer Issue Queue

This block is an out-of-order scheduling window that holds integer micro-ops until their source operands are available. It then hands them to two integer execution pipes, which draw on one common pool of entries. Dispatch can write zero, one or two micro-ops per cycle. Each micro-op names its sources and its destination by physical register tag, so readiness is tracked by comparing tags broadcast on a wakeup bus. No operand values pass through the queue.

The two pipes are not identical. Both execute plain and multi-cycle integer operations, but multiplication exists only on pipe 0 and division only on pipe 1. Selection therefore steers each ready micro-op by its class. Within what each pipe may accept, the oldest ready entry wins. A flush input empties the whole window in one cycle.

Issue ports are combinational views of the registered window. An entry shown on a port in a cycle leaves the queue at the next clock edge. The receiving pipes always accept.

Top module: `shared_int_iq`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is high and neither issue port is valid.
- R2: When `disp_ready` is high, every lane with `disp_valid` set is written in that cycle. Lane 0 counts as older than lane 1. A micro-op written with both sources ready is shown on an issue port in the following cycle.
- R3: `disp_ready` is high exactly when at least two entries are free. A dispatch presented while it is low is dropped.
- R4: Class codes are 0 = simple, 1 = complex, 2 = multiply, 3 = divide. Class 2 issues only on pipe 0, class 3 only on pipe 1, and classes 0 and 1 on either pipe.
- R5: Among the entries a pipe may take, the oldest ready one is issued, whatever slot it occupies. Pipe 1 never takes the entry chosen by pipe 0, and an issued entry is never issued again.
- R6: A source becomes ready when a valid wakeup port carries its tag. An entry issues only when both of its sources are ready. It appears on a port no earlier than the cycle after the wakeup that completed it.
- R7: A wakeup tag present in the same cycle as a dispatch marks the matching source of the new entry ready.
- R8: `flush` forces both issue ports invalid in its cycle. It clears every entry and discards any dispatch in that cycle, so later wakeups issue nothing from before the flush.
- R9: Both pipes can issue in the same cycle, each carrying at most one micro-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| flush | input | 1 | Empty the queue |
| disp_valid | input | 2 | Per-lane dispatch valid |
| disp_ready | output | 1 | Queue can take two micro-ops |
| disp_cls | input | 2*CLS_W | Per-lane class code |
| disp_src_a | input | 2*TAG_W | Per-lane first source tag |
| disp_src_a_rdy | input | 2 | Per-lane first source already ready |
| disp_src_b | input | 2*TAG_W | Per-lane second source tag |
| disp_src_b_rdy | input | 2 | Per-lane second source already ready |
| disp_dst | input | 2*TAG_W | Per-lane destination tag |
| wake_valid | input | WK_PORTS | Per-port wakeup valid |
| wake_tag | input | WK_PORTS*TAG_W | Per-port wakeup tag |
| iss0_valid | output | 1 | Pipe 0 issue valid |
| iss0_cls | output | CLS_W | Pipe 0 class |
| iss0_src_a | output | TAG_W | Pipe 0 first source tag |
| iss0_src_b | output | TAG_W | Pipe 0 second source tag |
| iss0_dst | output | TAG_W | Pipe 0 destination tag |
| iss1_valid | output | 1 | Pipe 1 issue valid |
| iss1_cls | output | CLS_W | Pipe 1 class |
| iss1_src_a | output | TAG_W | Pipe 1 first source tag |
| iss1_src_b | output | TAG_W | Pipe 1 second source tag |
| iss1_dst | output | TAG_W | Pipe 1 destination tag |

## Verification
The age test makes the older micro-ops sit in higher slots than the newer ones and wakes all four together. A picker that favoured low slot numbers would issue the younger pair first. Two dividers or two multipliers dispatched together must drain one per cycle on the single capable pipe; steering that ignored class would send one of them down the wrong pipe. Further cases cover a wakeup that lands in the same cycle as the dispatch (a design that lost it would leave the entry stuck), an entry that waits on two tags (early issue after one), a dispatch presented while full (a phantom issue), and flush against both older entries and a same-cycle dispatch (issues from stale state).

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_SIMPLE  = 2'd0,
    CLS_COMPLEX = 2'd1,
    CLS_MUL     = 2'd2,
    CLS_DIV     = 2'd3
  } op_cls_e;

  // Pipe 0 owns the multiplier, pipe 1 owns the divider.
  function automatic logic pipe0_accepts(input logic [CLS_W-1:0] cls);
    return cls != CLS_DIV;
  endfunction

  function automatic logic pipe1_accepts(input logic [CLS_W-1:0] cls);
    return cls != CLS_MUL;
  endfunction

endpackage

// File: rtl/iq_alloc.sv
// Finds the two lowest-numbered free slots as one-hot vectors.
module iq_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] slot_a,
  output logic [N-1:0] slot_b,
  output logic         two_free
);

  logic found_a;
  logic found_b;

  always_comb begin
    slot_a  = '0;
    slot_b  = '0;
    found_a = 1'b0;
    found_b = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i]) begin
        if (!found_a) begin
          slot_a[i] = 1'b1;
          found_a   = 1'b1;
        end else if (!found_b) begin
          slot_b[i] = 1'b1;
          found_b   = 1'b1;
        end
      end
    end
  end

  assign two_free = found_b;

endmodule

// File: rtl/iq_pick.sv
// Oldest-first picker: ages of valid entries are unique ranks, 0 = oldest.
module iq_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 3
) (
  input  logic [N-1:0]       elig,
  input  logic [N*AGE_W-1:0] ages,
  output logic [N-1:0]       grant
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i] = elig[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] &&
            ages[j*AGE_W +: AGE_W] < ages[i*AGE_W +: AGE_W]) begin
          grant[i] = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/iq_entry.sv
// One scheduling slot: payload, source readiness, age rank.
module iq_entry
  import iq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int AGE_W = 3,
  parameter int WK    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [CLS_W-1:0]    wr_cls,
  input  logic [TAG_W-1:0]    wr_src_a,
  input  logic                wr_src_a_rdy,
  input  logic [TAG_W-1:0]    wr_src_b,
  input  logic                wr_src_b_rdy,
  input  logic [TAG_W-1:0]    wr_dst,
  input  logic [AGE_W-1:0]    wr_age,
  input  logic                iss_clr,
  input  logic                gone0_vld,
  input  logic [AGE_W-1:0]    gone0_age,
  input  logic                gone1_vld,
  input  logic [AGE_W-1:0]    gone1_age,
  input  logic [WK-1:0]       wake_valid,
  input  logic [WK*TAG_W-1:0] wake_tag,
  output logic                e_valid,
  output logic                e_ready,
  output logic [CLS_W-1:0]    e_cls,
  output logic [TAG_W-1:0]    e_src_a,
  output logic [TAG_W-1:0]    e_src_b,
  output logic [TAG_W-1:0]    e_dst,
  output logic [AGE_W-1:0]    e_age
);

  logic             vld_q, vld_d;
  logic [CLS_W-1:0] cls_q, cls_d;
  logic [TAG_W-1:0] sa_q, sa_d, sb_q, sb_d, dst_q, dst_d;
  logic             ra_q, ra_d, rb_q, rb_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             hit_wa, hit_wb, hit_a, hit_b;
  logic             payload_en;

  // Tag compare against every wakeup port.
  always_comb begin
    hit_wa = 1'b0;
    hit_wb = 1'b0;
    hit_a  = 1'b0;
    hit_b  = 1'b0;
    for (int p = 0; p < WK; p++) begin
      if (wake_valid[p]) begin
        if (wake_tag[p*TAG_W +: TAG_W] == wr_src_a) hit_wa = 1'b1;
        if (wake_tag[p*TAG_W +: TAG_W] == wr_src_b) hit_wb = 1'b1;
        if (wake_tag[p*TAG_W +: TAG_W] == sa_q)     hit_a  = 1'b1;
        if (wake_tag[p*TAG_W +: TAG_W] == sb_q)     hit_b  = 1'b1;
      end
    end
  end

  // Next state.
  always_comb begin
    vld_d = vld_q;
    cls_d = cls_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    dst_d = dst_q;
    ra_d  = ra_q;
    rb_d  = rb_q;
    age_d = age_q;
    if (flush) begin
      vld_d = 1'b0;
    end else if (wr_en) begin
      vld_d = 1'b1;
      cls_d = wr_cls;
      sa_d  = wr_src_a;
      sb_d  = wr_src_b;
      dst_d = wr_dst;
      ra_d  = wr_src_a_rdy | hit_wa;
      rb_d  = wr_src_b_rdy | hit_wb;
      age_d = wr_age;
    end else if (vld_q) begin
      if (iss_clr) vld_d = 1'b0;
      ra_d  = ra_q | hit_a;
      rb_d  = rb_q | hit_b;
      age_d = age_q
            - AGE_W'(gone0_vld && (gone0_age < age_q))
            - AGE_W'(gone1_vld && (gone1_age < age_q));
    end
  end

  assign payload_en = wr_en | vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (payload_en) begin
      cls_q <= cls_d;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      dst_q <= dst_d;
      ra_q  <= ra_d;
      rb_q  <= rb_d;
      age_q <= age_d;
    end
  end

  assign e_valid = vld_q;
  assign e_ready = vld_q & ra_q & rb_q;
  assign e_cls   = cls_q;
  assign e_src_a = sa_q;
  assign e_src_b = sb_q;
  assign e_dst   = dst_q;
  assign e_age   = age_q;

endmodule

// File: rtl/shared_int_iq.sv
module shared_int_iq
  import iq_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int TAG_W    = 6,
  parameter int WK_PORTS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [1:0]                disp_valid,
  output logic                      disp_ready,
  input  logic [2*CLS_W-1:0]        disp_cls,
  input  logic [2*TAG_W-1:0]        disp_src_a,
  input  logic [1:0]                disp_src_a_rdy,
  input  logic [2*TAG_W-1:0]        disp_src_b,
  input  logic [1:0]                disp_src_b_rdy,
  input  logic [2*TAG_W-1:0]        disp_dst,
  input  logic [WK_PORTS-1:0]       wake_valid,
  input  logic [WK_PORTS*TAG_W-1:0] wake_tag,
  output logic                      iss0_valid,
  output logic [CLS_W-1:0]          iss0_cls,
  output logic [TAG_W-1:0]          iss0_src_a,
  output logic [TAG_W-1:0]          iss0_src_b,
  output logic [TAG_W-1:0]          iss0_dst,
  output logic                      iss1_valid,
  output logic [CLS_W-1:0]          iss1_cls,
  output logic [TAG_W-1:0]          iss1_src_a,
  output logic [TAG_W-1:0]          iss1_src_b,
  output logic [TAG_W-1:0]          iss1_dst
);

  localparam int AGE_W = (ENTRIES > 2) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]       e_valid, e_ready;
  logic [CLS_W-1:0]         e_cls   [ENTRIES];
  logic [TAG_W-1:0]         e_src_a [ENTRIES];
  logic [TAG_W-1:0]         e_src_b [ENTRIES];
  logic [TAG_W-1:0]         e_dst   [ENTRIES];
  logic [ENTRIES*AGE_W-1:0] e_age_flat;

  logic [ENTRIES-1:0] slot_a, slot_b;
  logic               two_free;
  logic               accept;
  logic               lane_of_a;
  logic [ENTRIES-1:0] wr_en;
  logic [ENTRIES-1:0] elig0, elig1, grant0, grant1, fire;
  logic               fire0, fire1;
  logic [AGE_W-1:0]   age0, age1, surv, age_wr_a, age_wr_b;

  // ---------------- allocation ----------------
  iq_alloc #(.N(ENTRIES)) u_alloc (
    .busy     (e_valid),
    .slot_a   (slot_a),
    .slot_b   (slot_b),
    .two_free (two_free)
  );

  assign disp_ready = two_free;
  assign accept     = two_free & ~flush;
  // A lone lane-1 op takes the first free slot.
  assign lane_of_a  = ~disp_valid[0];

  // Ranks for new entries: survivors of this cycle are all older.
  always_comb begin
    surv = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      surv = surv + AGE_W'(e_valid[i] & ~fire[i]);
    end
    age_wr_a = surv;
    age_wr_b = surv + AGE_W'(1);
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wr_en[i] = accept & ((slot_a[i] & (|disp_valid)) | (slot_b[i] & (&disp_valid)));
    end
  end

  // ---------------- selection ----------------
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      elig0[i] = e_ready[i] & pipe0_accepts(e_cls[i]);
    end
  end

  iq_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_pick0 (
    .elig  (elig0),
    .ages  (e_age_flat),
    .grant (grant0)
  );

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      elig1[i] = e_ready[i] & pipe1_accepts(e_cls[i]) & ~grant0[i];
    end
  end

  iq_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_pick1 (
    .elig  (elig1),
    .ages  (e_age_flat),
    .grant (grant1)
  );

  assign fire0 = (|grant0) & ~flush;
  assign fire1 = (|grant1) & ~flush;
  assign fire  = (grant0 | grant1) & {ENTRIES{~flush}};

  // Issue muxes (grants are one-hot).
  always_comb begin
    iss0_cls   = '0;
    iss0_src_a = '0;
    iss0_src_b = '0;
    iss0_dst   = '0;
    iss1_cls   = '0;
    iss1_src_a = '0;
    iss1_src_b = '0;
    iss1_dst   = '0;
    age0       = '0;
    age1       = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant0[i]) begin
        iss0_cls   = iss0_cls   | e_cls[i];
        iss0_src_a = iss0_src_a | e_src_a[i];
        iss0_src_b = iss0_src_b | e_src_b[i];
        iss0_dst   = iss0_dst   | e_dst[i];
        age0       = age0       | e_age_flat[i*AGE_W +: AGE_W];
      end
      if (grant1[i]) begin
        iss1_cls   = iss1_cls   | e_cls[i];
        iss1_src_a = iss1_src_a | e_src_a[i];
        iss1_src_b = iss1_src_b | e_src_b[i];
        iss1_dst   = iss1_dst   | e_dst[i];
        age1       = age1       | e_age_flat[i*AGE_W +: AGE_W];
      end
    end
  end

  assign iss0_valid = fire0;
  assign iss1_valid = fire1;

  // ---------------- entry array ----------------
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             use_b;
    logic             lane;
    logic [AGE_W-1:0] age_i;

    assign use_b = slot_b[g];
    assign lane  = use_b ? 1'b1 : lane_of_a;

    iq_entry #(.TAG_W(TAG_W), .AGE_W(AGE_W), .WK(WK_PORTS)) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .wr_en        (wr_en[g]),
      .wr_cls       (lane ? disp_cls[CLS_W +: CLS_W]   : disp_cls[0 +: CLS_W]),
      .wr_src_a     (lane ? disp_src_a[TAG_W +: TAG_W] : disp_src_a[0 +: TAG_W]),
      .wr_src_a_rdy (disp_src_a_rdy[lane]),
      .wr_src_b     (lane ? disp_src_b[TAG_W +: TAG_W] : disp_src_b[0 +: TAG_W]),
      .wr_src_b_rdy (disp_src_b_rdy[lane]),
      .wr_dst       (lane ? disp_dst[TAG_W +: TAG_W]   : disp_dst[0 +: TAG_W]),
      .wr_age       (use_b ? age_wr_b : age_wr_a),
      .iss_clr      (fire[g]),
      .gone0_vld    (fire0),
      .gone0_age    (age0),
      .gone1_vld    (fire1),
      .gone1_age    (age1),
      .wake_valid   (wake_valid),
      .wake_tag     (wake_tag),
      .e_valid      (e_valid[g]),
      .e_ready      (e_ready[g]),
      .e_cls        (e_cls[g]),
      .e_src_a      (e_src_a[g]),
      .e_src_b      (e_src_b[g]),
      .e_dst        (e_dst[g]),
      .e_age        (age_i)
    );

    assign e_age_flat[g*AGE_W +: AGE_W] = age_i;
  end

endmodule

// File: rtl/iq_chk.sv
module iq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic [1:0]   disp_valid,
  input logic         disp_ready,
  input logic         iss0_valid,
  input logic [1:0]   iss0_cls,
  input logic         iss1_valid,
  input logic [1:0]   iss1_cls,
  input logic [N-1:0] occ
);

  // R4: multiply never leaves on pipe 1
  a_r4_mul_pipe0: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_valid |-> iss1_cls != 2'd2);

  // R4: divide never leaves on pipe 0
  a_r4_div_pipe1: assert property (@(posedge clk) disable iff (!rst_n)
    iss0_valid |-> iss0_cls != 2'd3);

  // R8: the queue is empty after a flush
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

  // R3: with dispatch blocked and nothing issuing, occupancy is frozen
  a_r3_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !iss0_valid && !iss1_valid && !flush)
      |=> $countones(occ) == $past($countones(occ)));

  // R2: an accepted pair with no issue adds exactly two entries
  a_r2_pair_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ready && (&disp_valid) && !flush && !iss0_valid && !iss1_valid)
      |=> $countones(occ) == $past($countones(occ)) + 2);

endmodule

bind shared_int_iq iq_chk #(.N(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .iss0_valid (iss0_valid),
  .iss0_cls   (iss0_cls),
  .iss1_valid (iss1_valid),
  .iss1_cls   (iss1_cls),
  .occ        (e_valid)
);

// File: tb/tb_shared_int_iq.sv
`timescale 1ns/1ps
module tb_shared_int_iq;

  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic [1:0]    disp_valid;
  logic          disp_ready;
  logic [3:0]    disp_cls;
  logic [2*TW-1:0] disp_src_a, disp_src_b, disp_dst;
  logic [1:0]    disp_src_a_rdy, disp_src_b_rdy;
  logic [1:0]    wake_valid;
  logic [2*TW-1:0] wake_tag;
  logic          iss0_valid, iss1_valid;
  logic [1:0]    iss0_cls, iss1_cls;
  logic [TW-1:0] iss0_src_a, iss0_src_b, iss0_dst;
  logic [TW-1:0] iss1_src_a, iss1_src_b, iss1_dst;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shared_int_iq dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_cls(disp_cls),
    .disp_src_a(disp_src_a), .disp_src_a_rdy(disp_src_a_rdy),
    .disp_src_b(disp_src_b), .disp_src_b_rdy(disp_src_b_rdy),
    .disp_dst(disp_dst), .wake_valid(wake_valid), .wake_tag(wake_tag),
    .iss0_valid(iss0_valid), .iss0_cls(iss0_cls), .iss0_src_a(iss0_src_a),
    .iss0_src_b(iss0_src_b), .iss0_dst(iss0_dst),
    .iss1_valid(iss1_valid), .iss1_cls(iss1_cls), .iss1_src_a(iss1_src_a),
    .iss1_src_b(iss1_src_b), .iss1_dst(iss1_dst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush = 1'b0; disp_valid = '0; disp_cls = '0;
    disp_src_a = '0; disp_src_b = '0; disp_dst = '0;
    disp_src_a_rdy = '0; disp_src_b_rdy = '0;
    wake_valid = '0; wake_tag = '0;
  endtask

  // Clock edge, settle, drop stimulus.
  task automatic step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic lane(input int l, input int cls, input int sa, input bit ra,
                      input int sb, input bit rb, input int dst);
    disp_valid[l] = 1'b1;
    disp_cls[l*2 +: 2] = 2'(cls);
    disp_src_a[l*TW +: TW] = TW'(sa);
    disp_src_a_rdy[l] = ra;
    disp_src_b[l*TW +: TW] = TW'(sb);
    disp_src_b_rdy[l] = rb;
    disp_dst[l*TW +: TW] = TW'(dst);
  endtask

  task automatic wake(input int p, input int tag);
    wake_valid[p] = 1'b1;
    wake_tag[p*TW +: TW] = TW'(tag);
  endtask

  task automatic expect_iss(input string req, input bit v0, input int d0,
                            input bit v1, input int d1);
    check({req, " iss0_valid"}, iss0_valid, v0);
    if (v0) check({req, " iss0_dst"}, iss0_dst, d0);
    check({req, " iss1_valid"}, iss1_valid, v1);
    if (v1) check({req, " iss1_dst"}, iss1_dst, d1);
  endtask

  task automatic t_reset();
    check("R1 disp_ready", disp_ready, 1);
    expect_iss("R1", 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    lane(0, 0, 1, 1, 2, 1, 5);
    step();
    expect_iss("R2 single ready op", 1, 5, 0, 0);
    check("R2 src_a passthrough", iss0_src_a, 1);
    check("R2 src_b passthrough", iss0_src_b, 2);
    step();
    expect_iss("R5 no second issue", 0, 0, 0, 0);
  endtask

  task automatic t_caps();
    lane(0, 2, 1, 1, 1, 1, 6);
    lane(1, 3, 1, 1, 1, 1, 7);
    step();
    expect_iss("R4 mul/div steering", 1, 6, 1, 7);
    check("R4 iss0 cls mul", iss0_cls, 2);
    check("R4 iss1 cls div", iss1_cls, 3);
    step();
    lane(0, 3, 1, 1, 1, 1, 8);
    lane(1, 3, 1, 1, 1, 1, 9);
    step();
    expect_iss("R4 two divs first", 0, 0, 1, 8);
    step();
    expect_iss("R4 two divs second", 0, 0, 1, 9);
    step();
    lane(0, 2, 1, 1, 1, 1, 10);
    lane(1, 2, 1, 1, 1, 1, 11);
    step();
    expect_iss("R4 two muls first", 1, 10, 0, 0);
    step();
    expect_iss("R4 two muls second", 1, 11, 0, 0);
    step();
    lane(0, 0, 1, 1, 1, 1, 12);
    lane(1, 1, 1, 1, 1, 1, 13);
    step();
    expect_iss("R9 dual issue", 1, 12, 1, 13);
    step();
    expect_iss("R9 drained", 0, 0, 0, 0);
  endtask

  task automatic t_age();
    lane(0, 0, 30, 0, 1, 1, 20);
    lane(1, 0, 30, 0, 1, 1, 21);
    step();
    expect_iss("R6 waiting ops hold", 0, 0, 0, 0);
    lane(0, 0, 31, 0, 1, 1, 22);
    lane(1, 0, 31, 0, 1, 1, 23);
    step();
    wake(0, 30);
    step();
    expect_iss("R6 woken pair", 1, 20, 1, 21);
    step();
    lane(0, 1, 31, 0, 1, 1, 24);
    lane(1, 1, 31, 0, 1, 1, 25);
    step();
    wake(1, 31);
    step();
    expect_iss("R5 oldest in high slots first", 1, 22, 1, 23);
    step();
    expect_iss("R5 younger after", 1, 24, 1, 25);
    step();
    expect_iss("R5 empty", 0, 0, 0, 0);
  endtask

  task automatic t_two_src();
    lane(0, 0, 41, 0, 42, 0, 26);
    step();
    wake(1, 41);
    step();
    expect_iss("R6 one of two sources", 0, 0, 0, 0);
    wake(0, 42);
    step();
    expect_iss("R6 both sources", 1, 26, 0, 0);
    step();
  endtask

  task automatic t_same_cycle();
    lane(0, 0, 43, 0, 1, 1, 27);
    wake(0, 43);
    step();
    expect_iss("R7 wake with dispatch", 1, 27, 0, 0);
    step();
  endtask

  task automatic t_full_flush();
    for (int k = 0; k < 4; k++) begin
      lane(0, 0, 50, 0, 1, 1, 30 + 2*k);
      lane(1, 0, 50, 0, 1, 1, 31 + 2*k);
      step();
      check("R3 disp_ready vs free count", disp_ready, (k < 3) ? 1 : 0);
    end
    lane(0, 0, 1, 1, 1, 1, 40);
    step();
    expect_iss("R3 dispatch while full dropped", 0, 0, 0, 0);
    wake(0, 50);
    step();
    expect_iss("R3 original oldest pair", 1, 30, 1, 31);
    flush = 1'b1;
    #1;
    expect_iss("R8 ports quiet during flush", 0, 0, 0, 0);
    step();
    check("R8 ready after flush", disp_ready, 1);
    expect_iss("R8 empty after flush", 0, 0, 0, 0);
    wake(0, 50);
    step();
    expect_iss("R8 stale wake issues nothing", 0, 0, 0, 0);
    lane(0, 0, 1, 1, 1, 1, 42);
    flush = 1'b1;
    step();
    expect_iss("R8 dispatch with flush dropped", 0, 0, 0, 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_caps();
    t_age();
    t_two_src();
    t_same_cycle();
    t_full_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule